// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block serialises and deserialises asynchronous characters on a pair of single-wire lines. A small set of configuration inputs chooses the character width (5 to 8 bits), whether a parity bit follows the data and of which sense, and whether one or two stop bits close the frame. The bit rate comes from a programmable divisor. Every bit spans four oversample ticks, and one tick lasts divisor-plus-one input clocks.

The transmit side accepts a byte with a valid/ready handshake and drives the serial output. The line idles high, each frame opens with a low start bit, and data goes out least significant bit first. The receive side watches the serial input and confirms a start bit half a bit in. It then samples every later bit at its centre and presents the character with a single-cycle valid strobe and two error flags. Each direction has its own enable input. The configuration is expected to stay stable while a frame is in flight.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset the serial output is high, `rx_valid` and both error flags are low, and `tx_ready` is high while `tx_enable` is high.
- R2: The width code maps to data bits as follows: 0 gives 8, 1 gives 7, 2 gives 6 and 3 gives 5. A frame is a low start bit followed by that many data bits, least significant first.
- R3: With `cfg_par_en` set, a parity bit follows the last data bit. `cfg_par_odd` = 1 makes the count of ones over data plus parity odd, and 0 makes it even.
- R4: A stop field of 0 ends the frame with one high stop bit. Any nonzero value ends it with two.
- R5: While `cfg_div_use` is 1, every bit on the line lasts exactly 4×(`cfg_div`+1) clock cycles, with the start bit beginning in the cycle after acceptance.
- R6: While `cfg_div_use` is 0, `cfg_div` has no effect and each bit lasts 4×(DEF_DIV+1) cycles.
- R7: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low from then until the edge that ends the last stop bit, and rises right after that edge.
- R8: The receiver confirms a start bit two oversample ticks after it first sees the line low. A low pulse shorter than that yields no character. Characters narrower than 8 bits are zero-extended in `rx_data`.
- R9: `rx_frame_err` is set with the character when any stop bit is sampled low.
- R10: `rx_par_err` is set with the character when parity is enabled and the received parity bit disagrees with the configured sense.
- R11: While `tx_enable` is low, `tx_ready` is low, no byte is accepted and the serial output stays high.
- R12: While `rx_enable` is low, no character is delivered, whatever the input line does.
- R13: Each received character produces a single-cycle `rx_valid` pulse. The error flags are only ever high together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | 2 | Data width code (0:8, 1:7, 2:6, 3:5 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop | input | 2 | 0: one stop bit, otherwise two |
| cfg_div | input | DIV_W | Bit-rate divisor D |
| cfg_div_use | input | 1 | Use `cfg_div`; when low DEF_DIV applies |
| tx_enable | input | 1 | Transmit direction enable |
| rx_enable | input | 1 | Receive direction enable |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_frame_err | output | 1 | Stop bit sampled low |
| rx_par_err | output | 1 | Parity mismatch |

## Verification
The bench builds the engine with DEF_DIV = 2, so the fallback bit lasts 12 clocks. It programs divisors of 1 and 3, giving 8- and 16-clock bits. These short bits keep every frame to a few hundred cycles. That lets the bench check each bit-centre position and the exact edge on which `tx_ready` returns, under all four width codes, both parity senses and both stop counts, and in both divisor modes. On the receive side, short bits also make it cheap to inject a sub-half-bit glitch, a corrupted parity bit and a low second stop bit.

// File: rtl/ufe_pkg.sv
package ufe_pkg;

  localparam int CHAR_MAX   = 8;
  localparam int FRAME_MAX  = 12;

  typedef enum logic [2:0] {
    RXS_IDLE,
    RXS_START,
    RXS_DATA,
    RXS_PAR,
    RXS_STOP
  } rx_state_t;

  // number of data bits for a width code (0:8 .. 3:5)
  function automatic logic [3:0] code_bits(input logic [1:0] code);
    return 4'd8 - {2'b00, code};
  endfunction

  // keep only the bits that belong to the character
  function automatic logic [7:0] char_mask(input logic [7:0] d, input logic [1:0] code);
    return d & (8'hFF >> code);
  endfunction

  // parity bit value: even -> xor of data, odd -> its inverse
  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] code, input logic odd);
    return (^char_mask(d, code)) ^ odd;
  endfunction

  // total bits on the line for one frame
  function automatic logic [3:0] frame_len(input logic [1:0] code, input logic pe,
                                           input logic [1:0] stop);
    return 4'd1 + code_bits(code) + {3'b000, pe} + ((stop != 2'b00) ? 4'd2 : 4'd1);
  endfunction

  // line image of a frame, bit 0 first on the wire; unused tail stays high
  function automatic logic [FRAME_MAX-1:0] frame_image(input logic [7:0] d, input logic [1:0] code,
                                                       input logic pe, input logic odd);
    logic [FRAME_MAX-1:0] f;
    int nb;
    f  = '1;
    f[0] = 1'b0;
    nb = int'(code_bits(code));
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (i < nb) f[i+1] = d[i];
    end
    if (pe) f[nb+1] = par_bit(d, code, odd);
    return f;
  endfunction

endpackage

// File: rtl/ufe_tick_gen.sv
module ufe_tick_gen #(
  parameter int DIV_W   = 23,
  parameter int DEF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_use,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] cnt_q;

  assign eff_div = div_use ? div : DIV_W'(DEF_DIV);
  assign tick    = !restart && (cnt_q >= eff_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (restart || cnt_q >= eff_div) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ufe_tx.sv
module ufe_tx
  import ufe_pkg::*;
#(
  parameter int DIV_W   = 23,
  parameter int DEF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [1:0]       cfg_stop,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_div_use,
  input  logic             enable,
  input  logic [7:0]       data,
  input  logic             valid,
  output logic             ready,
  output logic             accept,
  output logic             line
);
  logic                 busy_q;
  logic [FRAME_MAX-1:0] frame_q;
  logic [3:0]           idx_q;
  logic [3:0]           nbits_q;
  logic [1:0]           sub_q;
  logic                 tick;

  ufe_tick_gen #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_use(cfg_div_use), .div(cfg_div),
    .restart(!busy_q), .tick(tick)
  );

  assign ready  = enable && !busy_q;
  assign accept = valid && ready;
  assign line   = busy_q ? frame_q[idx_q] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      idx_q   <= '0;
      nbits_q <= '0;
      sub_q   <= '0;
    end else if (!enable) begin
      busy_q <= 1'b0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      frame_q <= frame_image(data, cfg_len, cfg_par_en, cfg_par_odd);
      nbits_q <= frame_len(cfg_len, cfg_par_en, cfg_stop);
      idx_q   <= '0;
      sub_q   <= '0;
    end else if (busy_q && tick) begin
      sub_q <= sub_q + 1'b1;
      if (sub_q == 2'd3) begin
        if (idx_q == nbits_q - 4'd1) busy_q <= 1'b0;
        else                         idx_q  <= idx_q + 4'd1;
      end
    end
  end
endmodule

// File: rtl/ufe_rx.sv
module ufe_rx
  import ufe_pkg::*;
#(
  parameter int DIV_W       = 23,
  parameter int DEF_DIV     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [1:0]       cfg_stop,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_div_use,
  input  logic             enable,
  input  logic             line,
  output logic             done,
  output logic [7:0]       data,
  output logic             valid,
  output logic             frame_err,
  output logic             par_err
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic      rx_s;
  rx_state_t state_q;
  logic [1:0] sub_q;
  logic [3:0] idx_q;
  logic [7:0] shreg_q;
  logic [1:0] c_len_q;
  logic       c_pe_q, c_odd_q, c_two_q;
  logic       perr_q, ferr_q;
  logic       tick, sample, stop_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  ufe_tick_gen #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_use(cfg_div_use), .div(cfg_div),
    .restart(state_q == RXS_IDLE), .tick(tick)
  );

  // half a bit for the start check, a whole bit afterwards
  assign sample   = (state_q != RXS_IDLE) && tick &&
                    ((state_q == RXS_START) ? (sub_q == 2'd1) : (sub_q == 2'd3));
  assign stop_bad = !rx_s;
  assign done     = sample && (state_q == RXS_STOP) && !(c_two_q && idx_q == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RXS_IDLE;
      sub_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      c_len_q   <= '0;
      c_pe_q    <= 1'b0;
      c_odd_q   <= 1'b0;
      c_two_q   <= 1'b0;
      perr_q    <= 1'b0;
      ferr_q    <= 1'b0;
      data      <= '0;
      valid     <= 1'b0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      valid     <= 1'b0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
      if (!enable) begin
        state_q <= RXS_IDLE;
      end else if (state_q == RXS_IDLE) begin
        if (!rx_s) begin
          state_q <= RXS_START;
          sub_q   <= '0;
          idx_q   <= '0;
          shreg_q <= '0;
          perr_q  <= 1'b0;
          ferr_q  <= 1'b0;
          c_len_q <= cfg_len;
          c_pe_q  <= cfg_par_en;
          c_odd_q <= cfg_par_odd;
          c_two_q <= (cfg_stop != 2'b00);
        end
      end else if (tick) begin
        sub_q <= sub_q + 1'b1;
        if (sample) begin
          sub_q <= '0;
          unique case (state_q)
            RXS_START: state_q <= rx_s ? RXS_IDLE : RXS_DATA;
            RXS_DATA: begin
              shreg_q[idx_q[2:0]] <= rx_s;
              if (idx_q == code_bits(c_len_q) - 4'd1) begin
                idx_q   <= '0;
                state_q <= c_pe_q ? RXS_PAR : RXS_STOP;
              end else begin
                idx_q <= idx_q + 4'd1;
              end
            end
            RXS_PAR: begin
              perr_q  <= (rx_s != par_bit(shreg_q, c_len_q, c_odd_q));
              state_q <= RXS_STOP;
            end
            RXS_STOP: begin
              if (done) begin
                valid     <= 1'b1;
                data      <= shreg_q;
                frame_err <= ferr_q | stop_bad;
                par_err   <= perr_q;
                state_q   <= RXS_IDLE;
              end else begin
                ferr_q <= stop_bad;
                idx_q  <= 4'd1;
              end
            end
            default: state_q <= RXS_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine #(
  parameter int DIV_W       = 23,
  parameter int DEF_DIV     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [1:0]       cfg_stop,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_div_use,
  input  logic             tx_enable,
  input  logic             rx_enable,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_frame_err,
  output logic             rx_par_err
);
  // internal events, observed by the bound checker
  logic tx_accept;
  logic rx_done;

  ufe_tx #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .cfg_div(cfg_div), .cfg_div_use(cfg_div_use),
    .enable(tx_enable), .data(tx_data), .valid(tx_valid),
    .ready(tx_ready), .accept(tx_accept), .line(txd)
  );

  ufe_rx #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .cfg_div(cfg_div), .cfg_div_use(cfg_div_use),
    .enable(rx_enable), .line(rxd), .done(rx_done),
    .data(rx_data), .valid(rx_valid), .frame_err(rx_frame_err), .par_err(rx_par_err)
  );
endmodule

// File: rtl/ufe_checker.sv
module ufe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_len,
  input logic       tx_enable,
  input logic       rx_enable,
  input logic       tx_ready,
  input logic       txd,
  input logic       tx_accept,
  input logic       rx_done,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_frame_err,
  input logic       rx_par_err
);
  AST_TX_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && $past(!tx_enable)) |-> txd); // R11
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> !txd); // R2
  AST_TX_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> !tx_ready); // R7
  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !rx_valid); // R12
  AST_RX_DONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_valid); // R13
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R13
  AST_RX_FLAGS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_err || rx_par_err) |-> rx_valid); // R13
  AST_RX_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_len == 2'd3) |-> (rx_data[7:5] == 3'b000)); // R8
endmodule

bind uart_frame_engine ufe_checker u_ufe_checker (
  .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len),
  .tx_enable(tx_enable), .rx_enable(rx_enable),
  .tx_ready(tx_ready), .txd(txd), .tx_accept(tx_accept),
  .rx_done(rx_done), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err)
);

// File: tb/test_uart_frame_engine.sv
module test_uart_frame_engine;
  localparam int DIV_W   = 23;
  localparam int DEF_DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_len = '0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = '0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic cfg_div_use = 1'b0;
  logic tx_enable = 1'b1, rx_enable = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, txd;
  logic rxd = 1'b1;
  logic [7:0] rx_data;
  logic rx_valid, rx_frame_err, rx_par_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_frame_engine #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) i_uart_frame_engine (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop), .cfg_div(cfg_div),
    .cfg_div_use(cfg_div_use), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // expected wire image, built from the requirement text
  task automatic make_bits(input logic [7:0] d, input int len, input bit pe, input bit odd,
                           input int stop, output logic [11:0] bits, output int total);
    int nb, ones;
    nb = 8 - len;
    ones = 0;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bits[i+1] = d[i];
      if (d[i]) ones++;
    end
    total = 1 + nb;
    if (pe) begin
      bits[total] = odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
      total++;
    end
    total += (stop != 0) ? 2 : 1;
  endtask

  task automatic set_cfg(input int len, input bit pe, input bit odd, input int stop,
                         input bit use_div, input int dv);
    cfg_len = 2'(len); cfg_par_en = pe; cfg_par_odd = odd;
    cfg_stop = 2'(stop); cfg_div_use = use_div; cfg_div = DIV_W'(dv);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    chk(rx_valid == 1'b0 && rx_frame_err == 1'b0 && rx_par_err == 1'b0, "R1 rx quiet",
        int'(rx_valid), 0);
    chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
  endtask

  task automatic t_tx(input logic [7:0] d, input int len, input bit pe, input bit odd,
                      input int stop, input bit use_div, input int dv, input string req);
    logic [11:0] bits;
    int total, bt, acc;
    make_bits(d, len, pe, odd, stop, bits, total);
    bt = 4 * ((use_div ? dv : DEF_DIV) + 1);
    @(negedge clk);
    set_cfg(len, pe, odd, stop, use_div, dv);
    tx_data = d; tx_valid = 1'b1;
    chk(tx_ready == 1'b1, "R7 ready before accept", int'(tx_ready), 1);
    @(negedge clk);
    acc = cyc;
    tx_valid = 1'b0;
    for (int i = 0; i < total; i++) begin
      while (cyc < acc + i * bt + bt / 2) @(negedge clk);
      chk(txd == bits[i], req, int'(txd), int'(bits[i]));
      if (i == 0) chk(tx_ready == 1'b0, "R7 busy", int'(tx_ready), 0);
    end
    while (cyc < acc + total * bt - 1) @(negedge clk);
    chk(tx_ready == 1'b0, "R7 ready held low to frame end", int'(tx_ready), 0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R7 ready after frame", int'(tx_ready), 1);
  endtask

  task automatic t_rx(input logic [7:0] d, input int len, input bit pe, input bit odd,
                      input int stop, input bit use_div, input int dv,
                      input bit bad_par, input bit bad_stop, input string req);
    logic [11:0] bits;
    int total, bt, nval;
    logic [7:0] got;
    logic fe, pe_f;
    make_bits(d, len, pe, odd, stop, bits, total);
    if (bad_par) bits[9 - len] = ~bits[9 - len];
    if (bad_stop) bits[total - 1] = 1'b0;
    bt = 4 * ((use_div ? dv : DEF_DIV) + 1);
    nval = 0; got = '0; fe = 1'b0; pe_f = 1'b0;
    @(negedge clk);
    set_cfg(len, pe, odd, stop, use_div, dv);
    fork
      begin
        for (int i = 0; i < total; i++) begin
          rxd = bits[i];
          repeat (bt) @(negedge clk);
        end
        rxd = 1'b1;
      end
      begin
        for (int k = 0; k < (total + 3) * bt; k++) begin
          @(negedge clk);
          if (rx_valid) begin
            nval++; got = rx_data; fe = rx_frame_err; pe_f = rx_par_err;
          end
        end
      end
    join
    chk(nval == 1, "R13 one strobe", nval, 1);
    chk(got == (d & (8'hFF >> len)), req, int'(got), int'(d & (8'hFF >> len)));
    chk(fe == bad_stop, "R9 frame_err", int'(fe), int'(bad_stop));
    chk(pe_f == bad_par, "R10 par_err", int'(pe_f), int'(bad_par));
  endtask

  task automatic t_glitch();
    int nval;
    nval = 0;
    @(negedge clk);
    set_cfg(0, 0, 0, 0, 1, 1);
    rxd = 1'b0;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rx_valid) nval++;
    end
    chk(nval == 0, "R8 glitch rejected", nval, 0);
  endtask

  task automatic t_tx_disable();
    int bad;
    bad = 0;
    @(negedge clk);
    tx_enable = 1'b0; tx_data = 8'h00; tx_valid = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (txd != 1'b1 || tx_ready != 1'b0) bad++;
    end
    chk(bad == 0, "R11 disabled tx idle", bad, 0);
    tx_valid = 1'b0; tx_enable = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && tx_ready == 1'b1, "R11 nothing queued", int'(txd), 1);
  endtask

  task automatic t_rx_disable();
    logic [11:0] bits;
    int total, nval;
    make_bits(8'h5A, 0, 0, 0, 0, bits, total);
    nval = 0;
    @(negedge clk);
    set_cfg(0, 0, 0, 0, 1, 1);
    rx_enable = 1'b0;
    fork
      begin
        for (int i = 0; i < total; i++) begin
          rxd = bits[i];
          repeat (8) @(negedge clk);
        end
        rxd = 1'b1;
      end
      begin
        for (int k = 0; k < (total + 3) * 8; k++) begin
          @(negedge clk);
          if (rx_valid) nval++;
        end
      end
    join
    chk(nval == 0, "R12 disabled rx silent", nval, 0);
    rx_enable = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx(8'hA5, 0, 0, 0, 0, 1, 1, "R2 tx 8 bits");
    t_tx(8'hFF, 1, 0, 0, 0, 1, 1, "R2 tx 7 bits");
    t_tx(8'h35, 2, 1, 0, 0, 1, 3, "R3 tx even parity");
    t_tx(8'h35, 3, 1, 1, 1, 1, 1, "R3 tx odd parity 5 bits");
    t_tx(8'h81, 0, 0, 0, 1, 1, 3, "R4 tx two stops");
    t_tx(8'h6C, 0, 1, 1, 2, 1, 3, "R5 tx bit time D=3");
    t_tx(8'h3C, 0, 0, 0, 0, 0, 1, "R6 tx default divisor");
    t_rx(8'hC3, 0, 0, 0, 0, 1, 1, 0, 0, "R2 rx 8 bits");
    t_rx(8'hFF, 3, 1, 0, 0, 1, 1, 0, 0, "R8 rx zero-extend");
    t_rx(8'h9B, 1, 1, 1, 1, 1, 3, 0, 0, "R3 rx odd parity");
    t_rx(8'h47, 0, 1, 0, 0, 0, 3, 1, 0, "R10 rx bad parity");
    t_rx(8'h12, 2, 0, 0, 1, 1, 1, 0, 1, "R9 rx low second stop");
    t_rx(8'hE7, 0, 0, 0, 0, 1, 1, 0, 1, "R9 rx low stop");
    t_glitch();
    t_rx(8'h5E, 0, 0, 0, 0, 1, 1, 0, 0, "R8 rx after glitch");
    t_tx_disable();
    t_rx_disable();
    t_rx(8'h21, 0, 0, 0, 0, 1, 1, 0, 0, "R12 rx after re-enable");
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule